// File: doc/BRIEF.md
# Debug-Aware JTAG Test Access Port

This block is the JTAG test access port of a DSP core. It holds the 16-state TAP controller, a 4-bit instruction register, the 1-bit bypass and 32-bit identification data registers, and the decode for the boundary-scan instructions and two debug instructions. Where a standard port captures a fixed pattern in Capture-IR, this one captures a live status code built from the core's mode input. A host can therefore read the core's mode with every instruction scan and spot a broken link by a clear bit 0.

One debug instruction pulses a request line that asks the core to enter debug mode. The host then polls by scanning the instruction register again until the captured status reads 0xD. The other debug instruction routes the data-register path to an external on-chip debug register file through a select line and capture, shift and update strobes. The boundary-scan chain lives outside the block and uses the same strobes. The TAP state machine advances on the rising edge of TCK. TDO is retimed on the falling edge.

Top module: `dbg_tap_port`

## Requirements
- R1: Holding `rst_n` low at a rising TCK edge, or passing through Test-Logic-Reset, makes IDCODE (0x2) the current instruction. Afterwards `pin_extest`, `pin_clamp`, `pin_hiz`, `bsr_sel`, `dp_sel` and `dbg_req` are low.
- R2: The controller follows the standard 16-state TAP graph on TMS at each rising TCK edge. Five TCK cycles with TMS high reach Test-Logic-Reset from any state, including the middle of an instruction shift.
- R3: Capture-IR loads `{core_mode, 2'b01}`. This gives 0x1 for mode 0 (running), 0x5 for mode 1 (stop/wait), 0x9 for mode 2 (busy) and 0xD for mode 3 (debug), so bit 0 is always 1. The register shifts LSB first from TDI toward TDO and takes effect at Update-IR.
- R4: Update-IR with the value 0x7 raises `dbg_req` for exactly one TCK cycle, the cycle after Update-IR. It does so again on every reload of 0x7, and no other value raises it.
- R5: Instruction 0x2 selects a 32-bit register. It captures `IDCODE_VAL` with bit 0 forced to 1 and shifts it out LSB first.
- R6: Instructions 0xF, 0x3, 0x4, 0x7 and the undefined codes 0x5 and 0x8 to 0xE select the 1-bit bypass register. That register captures 0, so data leaves one cycle late behind a leading 0.
- R7: Instructions 0x0 and 0x1 raise `bsr_sel`, and shifted data on TDO comes from `bsr_so`.
- R8: Instruction 0x6 raises `dp_sel`, and shifted data on TDO comes from `dp_so`.
- R9: `dr_capture`, `dr_shift` and `dr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while `bsr_sel` or `dp_sel` is high.
- R10: `pin_extest` is high for instruction 0x0, `pin_clamp` for 0x3 and `pin_hiz` for 0x4, and each is low for all other instructions.
- R11: TDO and `tdo_en` change only on the falling edge of TCK. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR, and TDO is 0 whenever `tdo_en` is low.
- R12: The status shifted out is the mode present at the Capture-IR edge. A change of `core_mode` during the shift that follows does not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high during shift states |
| core_mode | input | 2 | Core mode: 0 running, 1 stop/wait, 2 busy, 3 debug |
| dbg_req | output | 1 | One-cycle request for the core to enter debug mode |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| dp_sel | output | 1 | On-chip debug register file is the selected data register |
| dr_capture | output | 1 | Capture strobe for the selected external register |
| dr_shift | output | 1 | Shift enable for the selected external register |
| dr_update | output | 1 | Update strobe for the selected external register |
| bsr_so | input | 1 | Serial output of the boundary chain |
| dp_so | input | 1 | Serial output of the debug register file |
| pin_extest | output | 1 | Pins driven from the boundary chain |
| pin_clamp | output | 1 | Pins clamped to the boundary chain's preload values |
| pin_hiz | output | 1 | All outputs forced to high impedance |

## Verification
Two functions can coincide in this block. The debug-request pulse caused by one instruction load can land next to the status capture that starts the host's next poll. The mode input can also change while a captured status is still being shifted out. The bench plays the core by hand. It loads the request while the mode reads "running" and polls without acknowledging, then expects 0x1 and a second pulse. It then sets the debug mode right after the pulse and expects 0xD on the next capture. In a separate scan it changes the mode after the first shift cycle and expects the status captured at the capture edge, not the new one.

// File: rtl/dbg_tap_pkg.sv
// Shared types for the debug-aware TAP: controller states, instruction
// codes, the data-register path choice and the status-code builder.
package dbg_tap_pkg;

    localparam int IR_W   = 4;
    localparam int MODE_W = 2;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS   = 2'd0,
        PATH_IDENT    = 2'd1,
        PATH_BOUNDARY = 2'd2,
        PATH_DBGPORT  = 2'd3
    } dr_path_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h1;
    localparam logic [IR_W-1:0] OP_IDENT   = 4'h2;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'h3;
    localparam logic [IR_W-1:0] OP_HIZ     = 4'h4;
    localparam logic [IR_W-1:0] OP_DBGPORT = 4'h6;
    localparam logic [IR_W-1:0] OP_DBGREQ  = 4'h7;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

    // Map an instruction to the data register it places between TDI and TDO.
    function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
        dr_path_e p;
        case (op)
            OP_IDENT:              p = PATH_IDENT;
            OP_EXTEST, OP_SAMPLE:  p = PATH_BOUNDARY;
            OP_DBGPORT:            p = PATH_DBGPORT;
            default:               p = PATH_BYPASS;
        endcase
        return p;
    endfunction

    // Status code captured in Capture-IR: mode on top, bit 1 clear, bit 0 set.
    function automatic logic [IR_W-1:0] status_of(input logic [MODE_W-1:0] mode);
        return {mode, {(IR_W-MODE_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
// TAP controller: the 16-state graph stepped by TMS on rising TCK.
// Assumes rst_n is synchronous to TCK; reset parks it in Test-Logic-Reset.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next state from the current state and TMS.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/dbg_tap_ir.sv
// Instruction register: captures the core status code, shifts LSB first,
// loads the current instruction at Update-IR and pulses the debug request.
// Assumes core_mode is stable (synchronised to TCK) outside this block.
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_e        state,
    input  logic              tdi,
    input  logic [MODE_W-1:0] core_mode,
    output logic [IR_W-1:0]   ir_q,
    output logic              ir_so,
    output logic              dbg_req
);

    logic [IR_W-1:0] ir_sh;

    // Capture/shift stage of the instruction register.
    always_ff @(posedge tck) begin
        if (!rst_n)                ir_sh <= '0;
        else if (state == ST_CAP_IR) ir_sh <= status_of(core_mode);
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Current instruction: IDCODE in reset, shifted value at Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_IDENT;
        else if (state == ST_UPD_IR)     ir_q <= ir_sh;
    end

    // One-cycle debug-entry request on each load of the request instruction.
    always_ff @(posedge tck) begin
        if (!rst_n) dbg_req <= 1'b0;
        else        dbg_req <= (state == ST_UPD_IR) && (ir_sh == OP_DBGREQ);
    end

    assign ir_so = ir_sh[0];

endmodule

// File: rtl/dbg_tap_dr.sv
// Data-register side: bypass and identification registers, the external
// register selects and strobes, and the serial-out multiplexer.
// Assumes external registers act on rising TCK when their strobes are high.
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h1A5C_301D
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    input  logic [IR_W-1:0] ir_q,
    input  logic            bsr_so,
    input  logic            dp_so,
    output logic            dr_so,
    output logic            bsr_sel,
    output logic            dp_sel,
    output logic            dr_capture,
    output logic            dr_shift,
    output logic            dr_update
);

    localparam logic [ID_W-1:0] ID_FIXED = IDCODE_VAL | {{(ID_W-1){1'b0}}, 1'b1};

    dr_path_e        path;
    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            ext_sel;

    assign path    = path_of(ir_q);
    assign bsr_sel = (path == PATH_BOUNDARY);
    assign dp_sel  = (path == PATH_DBGPORT);
    assign ext_sel = bsr_sel | dp_sel;

    // Strobes for whichever external register is selected.
    assign dr_capture = ext_sel && (state == ST_CAP_DR);
    assign dr_shift   = ext_sel && (state == ST_SH_DR);
    assign dr_update  = ext_sel && (state == ST_UPD_DR);

    // Bypass bit: captures 0, passes TDI through one stage.
    always_ff @(posedge tck) begin
        if (!rst_n)                                          byp_q <= 1'b0;
        else if (path == PATH_BYPASS && state == ST_CAP_DR)  byp_q <= 1'b0;
        else if (path == PATH_BYPASS && state == ST_SH_DR)   byp_q <= tdi;
    end

    // Identification register: captures the fixed code, shifts LSB first.
    always_ff @(posedge tck) begin
        if (!rst_n)                                         id_q <= ID_FIXED;
        else if (path == PATH_IDENT && state == ST_CAP_DR)  id_q <= ID_FIXED;
        else if (path == PATH_IDENT && state == ST_SH_DR)   id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Serial-out selection for the current data path.
    always_comb begin
        case (path)
            PATH_IDENT:    dr_so = id_q[0];
            PATH_BOUNDARY: dr_so = bsr_so;
            PATH_DBGPORT:  dr_so = dp_so;
            default:       dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/dbg_tap_port.sv
// Top of the debug-aware TAP: ties controller, instruction and data sides
// together, decodes the pin-control instructions and retimes TDO on the
// falling edge of TCK. Assumes a single TCK domain and synchronous rst_n.
module dbg_tap_port
    import dbg_tap_pkg::*;
#(
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h1A5C_301D
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic       tdo_en,
    input  logic [1:0] core_mode,
    output logic       dbg_req,
    output logic       bsr_sel,
    output logic       dp_sel,
    output logic       dr_capture,
    output logic       dr_shift,
    output logic       dr_update,
    input  logic       bsr_so,
    input  logic       dp_so,
    output logic       pin_extest,
    output logic       pin_clamp,
    output logic       pin_hiz
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    logic            dr_so;

    dbg_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    dbg_tap_ir u_ir (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (state),
        .tdi       (tdi),
        .core_mode (core_mode),
        .ir_q      (ir_q),
        .ir_so     (ir_so),
        .dbg_req   (dbg_req)
    );

    dbg_tap_dr #(
        .ID_W       (ID_W),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck        (tck),
        .rst_n      (rst_n),
        .state      (state),
        .tdi        (tdi),
        .ir_q       (ir_q),
        .bsr_so     (bsr_so),
        .dp_so      (dp_so),
        .dr_so      (dr_so),
        .bsr_sel    (bsr_sel),
        .dp_sel     (dp_sel),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update)
    );

    // Pin-control decode of the current instruction.
    assign pin_extest = (ir_q == OP_EXTEST);
    assign pin_clamp  = (ir_q == OP_CLAMP);
    assign pin_hiz    = (ir_q == OP_HIZ);

    // TDO and its enable, retimed on the falling edge of TCK.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else if (state == ST_SH_IR) begin
            tdo    <= ir_so;
            tdo_en <= 1'b1;
        end else if (state == ST_SH_DR) begin
            tdo    <= dr_so;
            tdo_en <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_tap_chk.sv
// Property checker for the debug-aware TAP, bound into the top module.
module dbg_tap_chk
    import dbg_tap_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       tms,
    input tap_state_e state,
    input logic       dbg_req,
    input logic       bsr_sel,
    input logic       dp_sel,
    input logic       dr_capture,
    input logic       dr_shift,
    input logic       dr_update,
    input logic       tdo_en,
    input logic       pin_extest,
    input logic       pin_clamp,
    input logic       pin_hiz
);

    a_r1_reset_state_clears: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (!pin_extest && !pin_clamp && !pin_hiz && !bsr_sel && !dp_sel));

    a_r2_reset_state_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    a_r2_idle_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IDLE && !tms) |=> (state == ST_IDLE));

    a_r4_req_single_cycle: assert property (@(posedge tck) disable iff (!rst_n)
        dbg_req |=> !dbg_req);

    a_r4_req_after_update: assert property (@(posedge tck) disable iff (!rst_n)
        dbg_req |-> ($past(state) == ST_UPD_IR));

    a_r7_selects_exclusive: assert property (@(posedge tck) disable iff (!rst_n)
        !(bsr_sel && dp_sel));

    a_r9_strobes_onehot: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({dr_capture, dr_shift, dr_update}));

    a_r9_strobes_need_select: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_capture || dr_shift || dr_update) |-> (bsr_sel || dp_sel));

    a_r10_pin_modes_onehot: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({pin_extest, pin_clamp, pin_hiz}));

    a_r11_enable_only_shifting: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind dbg_tap_port dbg_tap_chk u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tms        (tms),
    .state      (state),
    .dbg_req    (dbg_req),
    .bsr_sel    (bsr_sel),
    .dp_sel     (dp_sel),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .tdo_en     (tdo_en),
    .pin_extest (pin_extest),
    .pin_clamp  (pin_clamp),
    .pin_hiz    (pin_hiz)
);

// File: tb/dbg_tap_port_test.sv
`timescale 1ns/100ps
// Bench for the debug-aware TAP: sweeps all instruction codes and core modes.
module dbg_tap_port_test;

    localparam logic [31:0] ID_EXP = 32'h1A5C_301D | 32'h1;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [1:0] core_mode = 2'd0;
    logic       bsr_so = 1'b0;
    logic       dp_so = 1'b1;
    logic       tdo, tdo_en, dbg_req, bsr_sel, dp_sel;
    logic       dr_capture, dr_shift, dr_update;
    logic       pin_extest, pin_clamp, pin_hiz;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic seen_cap, seen_shift, seen_upd, seen_en;

    dbg_tap_port uut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_mode(core_mode), .dbg_req(dbg_req), .bsr_sel(bsr_sel), .dp_sel(dp_sel),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .bsr_so(bsr_so), .dp_so(dp_so), .pin_extest(pin_extest),
        .pin_clamp(pin_clamp), .pin_hiz(pin_hiz)
    );

    always #2 tck = ~tck;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One TCK cycle: drive after the falling edge, observe after the next one.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // Full instruction scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic ir_scan(input logic [3:0] op, input bit chg, input logic [1:0] newmode,
                           output logic [3:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        cap[0] = tdo;
        seen_en = tdo_en;
        for (int i = 0; i < 4; i++) begin
            if (chg && i == 1) core_mode = newmode;
            tick(i == 3, op[i]);
            if (i < 3) cap[i+1] = tdo;
        end
        tick(1, 0); tick(0, 0);
    endtask

    // Data scan of n bits, recording the strobes seen on the way.
    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tick(1, 0);
        tick(0, 0); seen_cap = dr_capture;
        tick(0, 0); seen_shift = dr_shift; seen_en = tdo_en;
        dout[0] = tdo;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            if (i < n - 1) dout[i+1] = tdo;
        end
        tick(1, 0); seen_upd = dr_update;
        tick(0, 0);
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        logic [3:0]  cap;
        logic [31:0] dout;
        logic [31:0] exp;

        // R1: synchronous reset state
        tick(1, 0); tick(1, 0); tick(1, 0);
        rst_n = 1'b1;
        tick(0, 0);
        chk("R1 pins", {pin_extest, pin_clamp, pin_hiz}, 0);
        chk("R1 selects", {bsr_sel, dp_sel, dbg_req}, 0);
        chk("R11 idle tdo", {tdo_en, tdo}, 0);
        dr_scan(32, 32'h0, dout);
        chk("R5 idcode after reset", dout, ID_EXP);
        chk("R11 enable in shift", seen_en, 1);

        // R3: status capture for every core mode
        for (int m = 0; m < 4; m++) begin
            core_mode = m[1:0];
            ir_scan(4'hF, 0, 0, cap);
            chk("R3 status code", cap, {m[1:0], 2'b01});
            chk("R3 bit0 set", cap[0], 1);
            chk("R11 enable in ir shift", seen_en, 1);
        end
        core_mode = 2'd0;

        // R4 R6 R7 R8 R9 R10: sweep of all instruction codes
        for (int k = 0; k < 16; k++) begin
            logic [3:0] op;
            op = k[3:0];
            ir_scan(op, 0, 0, cap);
            chk("R4 request pulse", dbg_req, (k == 7));
            chk("R10 extest", pin_extest, (k == 0));
            chk("R10 clamp", pin_clamp, (k == 3));
            chk("R10 hiz", pin_hiz, (k == 4));
            chk("R7 boundary select", bsr_sel, (k <= 1));
            chk("R8 debug port select", dp_sel, (k == 6));
            tick(0, 0);
            chk("R4 request one cycle", dbg_req, 0);
            dr_scan(8, 32'hCD, dout);
            if (k == 2)               exp = ID_EXP & 32'hFF;
            else if (k <= 1)          exp = 32'h0;
            else if (k == 6)          exp = 32'hFF;
            else                      exp = {24'h0, 8'hCD << 1} & 32'hFF;
            if (k == 2)               chk("R5 idcode low byte", dout, exp);
            else if (k <= 1)          chk("R7 boundary data", dout, exp);
            else if (k == 6)          chk("R8 debug port data", dout, exp);
            else                      chk("R6 bypass data", dout, exp);
            chk("R9 capture strobe", seen_cap, (k <= 1 || k == 6));
            chk("R9 shift strobe", seen_shift, (k <= 1 || k == 6));
            chk("R9 update strobe", seen_upd, (k <= 1 || k == 6));
            chk("R9 idle strobes", {dr_capture, dr_shift, dr_update}, 0);
        end

        // R12: mode change during the shift does not alter the captured status
        core_mode = 2'd1;
        ir_scan(4'hF, 1, 2'd2, cap);
        chk("R12 status held through shift", cap, 4'h5);
        ir_scan(4'hF, 0, 0, cap);
        chk("R12 next capture sees new mode", cap, 4'h9);

        // R3 R4: debug request followed by polling scans
        core_mode = 2'd0;
        ir_scan(4'h7, 0, 0, cap);
        chk("R4 request issued", dbg_req, 1);
        ir_scan(4'h7, 0, 0, cap);
        chk("R3 poll before entry", cap, 4'h1);
        chk("R4 request repeated", dbg_req, 1);
        core_mode = 2'd3;
        ir_scan(4'h7, 0, 0, cap);
        chk("R3 poll after entry", cap, 4'hD);
        chk("R4 request on reload", dbg_req, 1);

        // R2: five TMS-high cycles from inside an IR shift reach reset
        core_mode = 2'd0;
        ir_scan(4'h4, 0, 0, cap);
        chk("R10 hiz loaded", pin_hiz, 1);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 1);
        tick(0, 0);
        chk("R2 reset via tms", {pin_hiz, pin_clamp, pin_extest}, 0);
        dr_scan(32, 32'h0, dout);
        chk("R2 idcode after tms reset", dout, ID_EXP);

        // R1: synchronous reset clears a loaded instruction
        ir_scan(4'h3, 0, 0, cap);
        chk("R10 clamp loaded", pin_clamp, 1);
        rst_n = 1'b0;
        tick(0, 0);
        rst_n = 1'b1;
        chk("R1 reset clears clamp", pin_clamp, 0);
        tick(0, 0);
        dr_scan(32, 32'h0, dout);
        chk("R1 idcode after rst_n", dout, ID_EXP);

        // R11: TDO moves on the falling edge only
        ir_scan(4'hF, 0, 0, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R11 captured bypass", tdo, 0);
        tms = 1'b0;
        tdi = 1'b1;
        @(posedge tck);
        #1;
        chk("R11 tdo held after rising edge", tdo, 0);
        @(negedge tck);
        #1;
        chk("R11 tdo after falling edge", tdo, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);
        chk("R11 tdo idle after scan", {tdo_en, tdo}, 0);

        finish_up();
    end

endmodule